// File: doc/BRIEF.md
# DRAM Row-Buffer Page Policy Unit

This unit sits beside the command scheduler of a DRAM controller. It tracks which row each bank holds open. For every column access the scheduler issues, it decides whether that access should carry an auto-precharge. It closes a row once a fixed number of column accesses have hit it. Under the adaptive policy it can also close a row early: this happens when the pending queue holds no further hit to that row but does hold another request for the same bank.

With each decision the unit updates the bank's timing state: the ready time, the time at which the row may be closed, the count of banks with an open row, and the time at which every bank will be precharged. It also accumulates the bytes moved through each open row. When the row ends, it reports that total once.

Top module: `row_policy_unit`

## Requirements
- R1: An access to a bank with no open row, or with a different open row, makes the issued row that bank's open row. The bank's ready time becomes issue time plus `t_access_i`, and its row-close time becomes issue time plus `t_ras_i`. An access to the already open row leaves the row-close time unchanged.
- R2: Each bank counts column accesses to its open row. The access that brings the count to `MAX_ROW_ACC` has `auto_pre_o` set. The count restarts from zero when the row closes or is replaced.
- R3: With `MAX_ROW_ACC` = 1, every access auto-precharges. With `MAX_ROW_ACC` = 0, no access is ever closed by the count.
- R4: With `policy_i` = 0 (plain open), the pending queue has no effect on any output.
- R5: With `policy_i` = 1 (adaptive) and the count not reached, an access auto-precharges exactly when two conditions hold: no valid queue entry names the same bank and row, and at least one valid queue entry names the same bank with a different row.
- R6: Queue entries with their `q_valid_i` bit at 0 count as neither a hit nor a conflict.
- R7: On auto-precharge, the bank's open row is marked invalid. Its ready time becomes the larger of (issue time + `t_access_i`) and its row-close time, plus `t_rp_i`.
- R8: `active_banks_o` rises by one when an access targets a bank with no open row, and falls by one on each auto-precharge. Both can happen on the same access.
- R9: When an auto-precharge brings `active_banks_o` to zero, `all_pre_at_o` becomes the larger of its previous value and that bank's new ready time. Otherwise it holds.
- R10: Each access adds `issue_burst_i` to a per-bank byte total. When an access replaces an open row, `row_bytes_vld_o` pulses with the old row's total. When an access auto-precharges, it pulses with the total including this access. Either way, the total then restarts.
- R11: After reset, no bank has an open row, every ready time is zero, and `active_banks_o`, `all_pre_at_o`, `auto_pre_o` and `row_bytes_vld_o` are zero.
- R12: All outputs are registered and change at the clock edge that samples `issue_i`. Banks other than `issue_bank_i`, and all banks when `issue_i` is 0, keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | A column access is issued this cycle |
| issue_bank_i | input | BANK_W | Bank of the issued access |
| issue_row_i | input | ROW_W | Row of the issued access |
| issue_burst_i | input | BURST_W | Bytes moved by the issued access |
| q_valid_i | input | QUEUE_DEPTH | Valid bit of each pending queue entry |
| q_bank_i | input | QUEUE_DEPTH*BANK_W | Bank of each pending entry |
| q_row_i | input | QUEUE_DEPTH*ROW_W | Row of each pending entry |
| policy_i | input | 1 | 0 plain open, 1 adaptive |
| now_i | input | TIME_W | Current time |
| t_access_i | input | TIME_W | Access latency |
| t_ras_i | input | TIME_W | Minimum activate-to-precharge time |
| t_rp_i | input | TIME_W | Precharge time |
| open_row_o | output | NUM_BANKS*ROW_W | Open row of each bank |
| row_valid_o | output | NUM_BANKS | Bank holds an open row |
| ready_at_o | output | NUM_BANKS*TIME_W | Ready time of each bank |
| auto_pre_o | output | 1 | Last issued access carried auto-precharge |
| active_banks_o | output | ACT_W | Number of banks with an open row |
| all_pre_at_o | output | TIME_W | Time all banks are precharged |
| row_bytes_o | output | BYTES_W | Byte total of the row that just ended |
| row_bytes_vld_o | output | 1 | `row_bytes_o` is new this cycle |

## Verification
The bench builds three copies of the unit side by side, with `MAX_ROW_ACC` set to 3, 1 and 0, and feeds them identical stimulus. The small limit of 3 makes limit-driven closes frequent. The copies with limits 1 and 0 pin down close-every-access and never-close-by-count. The queue depth is 4 and the rows are 4 bits wide. Accesses are drawn from three busy banks and three rows, so hits, replacements and conflicts all occur often. Both policies are swept, and an arithmetic model checks every bank of every copy after each cycle.

// File: rtl/row_policy_pkg.sv
package row_policy_pkg;
  typedef enum logic {
    POL_OPEN     = 1'b0,
    POL_ADAPTIVE = 1'b1
  } page_pol_e;
endpackage

// File: rtl/queue_hit_scan.sv
module queue_hit_scan #(
  parameter int QUEUE_DEPTH = 8,
  parameter int BANK_W      = 3,
  parameter int ROW_W       = 14
) (
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [ROW_W-1:0]              row_i,
  input  logic [QUEUE_DEPTH-1:0]        q_valid_i,
  input  logic [QUEUE_DEPTH*BANK_W-1:0] q_bank_i,
  input  logic [QUEUE_DEPTH*ROW_W-1:0]  q_row_i,
  output logic                          hit_o,
  output logic                          conflict_o
);
  logic [QUEUE_DEPTH-1:0] same_bank, same_row;

  for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_entry
    assign same_bank[e] = q_valid_i[e] && (q_bank_i[e*BANK_W +: BANK_W] == bank_i);
    assign same_row[e]  = (q_row_i[e*ROW_W +: ROW_W] == row_i);
  end

  assign hit_o      = |(same_bank & same_row);
  assign conflict_o = |(same_bank & ~same_row);

  always_comb begin
    if (q_valid_i == '0) begin
      assert_scan_ignores_invalid_R6: assert (!hit_o && !conflict_o);
    end
  end
endmodule

// File: rtl/bank_state.sv
module bank_state #(
  parameter int ROW_W       = 14,
  parameter int TIME_W      = 32,
  parameter int BURST_W     = 8,
  parameter int BYTES_W     = 16,
  parameter int MAX_ROW_ACC = 16,
  localparam int CNT_W      = (MAX_ROW_ACC < 2) ? 2 : $clog2(MAX_ROW_ACC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic [TIME_W-1:0]  now_i,
  input  logic [TIME_W-1:0]  t_access_i,
  input  logic [TIME_W-1:0]  t_ras_i,
  input  logic [TIME_W-1:0]  t_rp_i,
  input  logic               early_close_i,
  output logic [ROW_W-1:0]   row_o,
  output logic               valid_o,
  output logic [TIME_W-1:0]  ready_o,
  output logic               fresh_o,
  output logic               close_o,
  output logic [TIME_W-1:0]  ready_nx_o,
  output logic               rpt_o,
  output logic [BYTES_W-1:0] rpt_bytes_o
);
  logic [ROW_W-1:0]   row_q;
  logic               valid_q;
  logic [TIME_W-1:0]  ready_q, ras_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTES_W-1:0] bytes_q;

  logic               new_row, limit_hit;
  logic [CNT_W-1:0]   cnt_base, cnt_inc;
  logic [TIME_W-1:0]  ras_nx, acc_ready, pre_base;
  logic [BYTES_W-1:0] bytes_acc;

  always_comb begin
    new_row   = !valid_q || (row_q != row_i);
    cnt_base  = new_row ? '0 : cnt_q;
    cnt_inc   = (&cnt_base) ? cnt_base : cnt_base + 1'b1;  // saturate when unlimited
    ras_nx    = new_row ? now_i + t_ras_i : ras_q;
    acc_ready = now_i + t_access_i;
    pre_base  = (acc_ready > ras_nx) ? acc_ready : ras_nx;
    bytes_acc = bytes_q + BYTES_W'(burst_i);
  end

  if (MAX_ROW_ACC == 0) begin : g_nolim
    assign limit_hit = 1'b0;
  end else begin : g_lim
    assign limit_hit = (cnt_inc == CNT_W'(MAX_ROW_ACC));

    assert_cnt_below_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> (cnt_q != '0) && (int'(cnt_q) < MAX_ROW_ACC));
  end

  assign close_o     = sel_i && (limit_hit || early_close_i);
  assign fresh_o     = sel_i && !valid_q;
  assign rpt_o       = sel_i && ((valid_q && new_row) || close_o);
  assign rpt_bytes_o = close_o ? bytes_acc : bytes_q;
  assign ready_nx_o  = close_o ? pre_base + t_rp_i : acc_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      valid_q <= 1'b0;
      ready_q <= '0;
      ras_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else if (sel_i) begin
      row_q   <= row_i;
      valid_q <= !close_o;
      ready_q <= ready_nx_o;
      ras_q   <= ras_nx;
      cnt_q   <= close_o ? '0 : cnt_inc;
      bytes_q <= close_o ? '0 : (new_row ? BYTES_W'(burst_i) : bytes_acc);
    end
  end

  assign row_o   = row_q;
  assign valid_o = valid_q;
  assign ready_o = ready_q;

  assert_idle_bank_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(row_q) && $stable(valid_q) && $stable(ready_q));

  assert_pre_ready_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && close_o) |=> !valid_q && (ready_q >= $past(acc_ready) + $past(t_rp_i)));

  assert_bytes_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && close_o) |=> (bytes_q == '0) && (cnt_q == '0));
endmodule

// File: rtl/row_policy_unit.sv
module row_policy_unit
  import row_policy_pkg::*;
#(
  parameter int  NUM_BANKS   = 8,
  parameter int  ROW_W       = 14,
  parameter int  TIME_W      = 32,
  parameter int  BURST_W     = 8,
  parameter int  BYTES_W     = 16,
  parameter int  QUEUE_DEPTH = 8,
  parameter int  MAX_ROW_ACC = 16,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ACT_W       = $clog2(NUM_BANKS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          issue_i,
  input  logic [BANK_W-1:0]             issue_bank_i,
  input  logic [ROW_W-1:0]              issue_row_i,
  input  logic [BURST_W-1:0]            issue_burst_i,
  input  logic [QUEUE_DEPTH-1:0]        q_valid_i,
  input  logic [QUEUE_DEPTH*BANK_W-1:0] q_bank_i,
  input  logic [QUEUE_DEPTH*ROW_W-1:0]  q_row_i,
  input  logic                          policy_i,
  input  logic [TIME_W-1:0]             now_i,
  input  logic [TIME_W-1:0]             t_access_i,
  input  logic [TIME_W-1:0]             t_ras_i,
  input  logic [TIME_W-1:0]             t_rp_i,
  output logic [NUM_BANKS*ROW_W-1:0]    open_row_o,
  output logic [NUM_BANKS-1:0]          row_valid_o,
  output logic [NUM_BANKS*TIME_W-1:0]   ready_at_o,
  output logic                          auto_pre_o,
  output logic [ACT_W-1:0]              active_banks_o,
  output logic [TIME_W-1:0]             all_pre_at_o,
  output logic [BYTES_W-1:0]            row_bytes_o,
  output logic                          row_bytes_vld_o
);
  logic q_hit, q_conf, early;

  queue_hit_scan #(
    .QUEUE_DEPTH(QUEUE_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_scan (
    .bank_i(issue_bank_i), .row_i(issue_row_i),
    .q_valid_i(q_valid_i), .q_bank_i(q_bank_i), .q_row_i(q_row_i),
    .hit_o(q_hit), .conflict_o(q_conf)
  );

  assign early = (page_pol_e'(policy_i) == POL_ADAPTIVE) && !q_hit && q_conf;

  logic [NUM_BANKS-1:0] fresh, close, rpt;
  logic [TIME_W-1:0]    ready_nx [NUM_BANKS];
  logic [BYTES_W-1:0]   rpt_b    [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_state #(
      .ROW_W(ROW_W), .TIME_W(TIME_W), .BURST_W(BURST_W),
      .BYTES_W(BYTES_W), .MAX_ROW_ACC(MAX_ROW_ACC)
    ) u_bank (
      .clk_i, .rst_ni,
      .sel_i        (issue_i && (issue_bank_i == BANK_W'(b))),
      .row_i        (issue_row_i),
      .burst_i      (issue_burst_i),
      .now_i, .t_access_i, .t_ras_i, .t_rp_i,
      .early_close_i(early),
      .row_o        (open_row_o[b*ROW_W +: ROW_W]),
      .valid_o      (row_valid_o[b]),
      .ready_o      (ready_at_o[b*TIME_W +: TIME_W]),
      .fresh_o      (fresh[b]),
      .close_o      (close[b]),
      .ready_nx_o   (ready_nx[b]),
      .rpt_o        (rpt[b]),
      .rpt_bytes_o  (rpt_b[b])
    );
  end

  logic             any_close;
  logic [ACT_W-1:0] active_q, active_nx;
  logic [TIME_W-1:0] all_pre_q, sel_ready;

  assign any_close = |close;
  assign sel_ready = ready_nx[issue_bank_i];
  assign active_nx = active_q + ACT_W'(|fresh) - ACT_W'(any_close);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_pre_o      <= 1'b0;
      row_bytes_vld_o <= 1'b0;
      row_bytes_o     <= '0;
      active_q        <= '0;
      all_pre_q       <= '0;
    end else begin
      auto_pre_o      <= any_close;
      row_bytes_vld_o <= |rpt;
      if (|rpt) row_bytes_o <= rpt_b[issue_bank_i];
      active_q <= active_nx;
      if (any_close && (active_nx == '0))
        all_pre_q <= (sel_ready > all_pre_q) ? sel_ready : all_pre_q;
    end
  end

  assign active_banks_o = active_q;
  assign all_pre_at_o   = all_pre_q;

  assert_active_matches_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(active_banks_o) == $countones(row_valid_o));

  assert_allpre_moves_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(all_pre_q) |-> (active_q == '0) && auto_pre_o);

  assert_ap_leaves_bank_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && any_close) |=> auto_pre_o && !row_valid_o[$past(issue_bank_i)]);

  assert_plain_open_no_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !policy_i |-> !early);
endmodule

// File: tb/row_policy_unit_bench.sv
module row_policy_unit_bench;
  localparam int NB = 8, ROW_W = 4, TIME_W = 32, BURST_W = 8, BYTES_W = 16, QD = 4;
  localparam int BANK_W = 3, ACT_W = 4, NI = 3;
  localparam int T_ACC = 5, T_RAS = 14, T_RP = 4;

  logic clk_i = 1'b0, rst_ni;
  always #5 clk_i = ~clk_i;

  logic                   issue_i, policy_i;
  logic [BANK_W-1:0]      issue_bank_i;
  logic [ROW_W-1:0]       issue_row_i;
  logic [BURST_W-1:0]     issue_burst_i;
  logic [QD-1:0]          q_valid_i;
  logic [QD*BANK_W-1:0]   q_bank_i;
  logic [QD*ROW_W-1:0]    q_row_i;
  logic [TIME_W-1:0]      now_q;

  initial now_q = '0;
  always @(posedge clk_i) now_q <= now_q + 1;

  logic [NB*ROW_W-1:0]  open_row_w [NI];
  logic [NB-1:0]        valid_w    [NI];
  logic [NB*TIME_W-1:0] ready_w    [NI];
  logic                 ap_w       [NI];
  logic [ACT_W-1:0]     active_w   [NI];
  logic [TIME_W-1:0]    allpre_w   [NI];
  logic [BYTES_W-1:0]   bytes_w    [NI];
  logic                 bvld_w     [NI];

  for (genvar g = 0; g < NI; g++) begin : g_inst
    localparam int LIMV = (g == 0) ? 3 : ((g == 1) ? 1 : 0);
    row_policy_unit #(
      .NUM_BANKS(NB), .ROW_W(ROW_W), .TIME_W(TIME_W), .BURST_W(BURST_W),
      .BYTES_W(BYTES_W), .QUEUE_DEPTH(QD), .MAX_ROW_ACC(LIMV)
    ) u_row_policy_unit (
      .clk_i, .rst_ni, .issue_i, .issue_bank_i, .issue_row_i, .issue_burst_i,
      .q_valid_i, .q_bank_i, .q_row_i, .policy_i,
      .now_i(now_q), .t_access_i(TIME_W'(T_ACC)), .t_ras_i(TIME_W'(T_RAS)),
      .t_rp_i(TIME_W'(T_RP)),
      .open_row_o(open_row_w[g]), .row_valid_o(valid_w[g]), .ready_at_o(ready_w[g]),
      .auto_pre_o(ap_w[g]), .active_banks_o(active_w[g]), .all_pre_at_o(allpre_w[g]),
      .row_bytes_o(bytes_w[g]), .row_bytes_vld_o(bvld_w[g])
    );
  end

  int lim [NI] = '{3, 1, 0};
  int m_row [NI][NB], m_ready [NI][NB], m_ras [NI][NB], m_cnt [NI][NB], m_bytes [NI][NB];
  bit m_valid [NI][NB];
  int m_active [NI], m_allpre [NI], e_bytes [NI];
  bit e_ap [NI], e_bvld [NI];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // model of one access, inputs taken from the driven ports
  task automatic model_step(int k);
    int b, r, bu, nw, cnt, rdy;
    bit hit, conf, nr, cl;
    e_ap[k] = 0; e_bvld[k] = 0;
    if (!issue_i) return;
    b = int'(issue_bank_i); r = int'(issue_row_i); bu = int'(issue_burst_i); nw = int'(now_q);
    hit = 0; conf = 0;
    for (int q = 0; q < QD; q++)
      if (q_valid_i[q] && int'(q_bank_i[q*BANK_W +: BANK_W]) == b) begin
        if (int'(q_row_i[q*ROW_W +: ROW_W]) == r) hit = 1; else conf = 1;
      end
    nr  = !m_valid[k][b] || m_row[k][b] != r;
    cnt = nr ? 1 : m_cnt[k][b] + 1;
    if (nr) m_ras[k][b] = nw + T_RAS;
    cl = (lim[k] != 0 && cnt == lim[k]) || (policy_i && !hit && conf);
    e_bvld[k]  = (m_valid[k][b] && nr) || cl;
    e_bytes[k] = m_bytes[k][b] + (cl ? bu : 0);
    rdy = nw + T_ACC;
    if (cl) rdy = ((rdy > m_ras[k][b]) ? rdy : m_ras[k][b]) + T_RP;
    m_active[k] = m_active[k] + (m_valid[k][b] ? 0 : 1) - (cl ? 1 : 0);
    if (cl && m_active[k] == 0 && rdy > m_allpre[k]) m_allpre[k] = rdy;
    m_bytes[k][b] = cl ? 0 : (nr ? bu : m_bytes[k][b] + bu);
    m_ready[k][b] = rdy; m_row[k][b] = r; m_valid[k][b] = !cl;
    m_cnt[k][b] = cl ? 0 : cnt;
    e_ap[k] = cl;
  endtask

  task automatic compare(int k);
    for (int b = 0; b < NB; b++) begin
      chk(valid_w[k][b] == m_valid[k][b], "R1 R12 row valid", int'(valid_w[k][b]), int'(m_valid[k][b]));
      if (m_valid[k][b])
        chk(int'(open_row_w[k][b*ROW_W +: ROW_W]) == m_row[k][b], "R1 open row",
            int'(open_row_w[k][b*ROW_W +: ROW_W]), m_row[k][b]);
      chk(int'(ready_w[k][b*TIME_W +: TIME_W]) == m_ready[k][b], "R1 R7 ready time",
          int'(ready_w[k][b*TIME_W +: TIME_W]), m_ready[k][b]);
    end
    chk(ap_w[k] == e_ap[k], "R2 R3 R4 R5 R6 auto precharge", int'(ap_w[k]), int'(e_ap[k]));
    chk(int'(active_w[k]) == m_active[k], "R8 active banks", int'(active_w[k]), m_active[k]);
    chk(int'(allpre_w[k]) == m_allpre[k], "R9 all precharged time", int'(allpre_w[k]), m_allpre[k]);
    chk(bvld_w[k] == e_bvld[k], "R10 bytes report valid", int'(bvld_w[k]), int'(e_bvld[k]));
    if (e_bvld[k]) chk(int'(bytes_w[k]) == e_bytes[k], "R10 bytes total", int'(bytes_w[k]), e_bytes[k]);
  endtask

  initial begin
    rst_ni = 1'b0; issue_i = 0; policy_i = 0; issue_bank_i = '0; issue_row_i = '0;
    issue_burst_i = '0; q_valid_i = '0; q_bank_i = '0; q_row_i = '0;
    for (int k = 0; k < NI; k++) begin
      m_active[k] = 0; m_allpre[k] = 0; e_ap[k] = 0; e_bvld[k] = 0; e_bytes[k] = 0;
      for (int b = 0; b < NB; b++) begin
        m_row[k][b] = 0; m_ready[k][b] = 0; m_ras[k][b] = 0;
        m_cnt[k][b] = 0; m_bytes[k][b] = 0; m_valid[k][b] = 0;
      end
    end
    void'($urandom(17));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < NI; k++) begin  // R11 reset state
      chk(valid_w[k] == '0, "R11 no open rows", int'(valid_w[k]), 0);
      chk(ready_w[k] == '0, "R11 ready times zero", int'(|ready_w[k]), 0);
      chk(active_w[k] == '0, "R11 active zero", int'(active_w[k]), 0);
      chk(allpre_w[k] == '0, "R11 all precharged zero", int'(allpre_w[k]), 0);
      chk(!ap_w[k] && !bvld_w[k], "R11 pulses low", int'(ap_w[k]) + int'(bvld_w[k]), 0);
    end
    for (int step = 0; step < 6000; step++) begin
      int b;
      policy_i = (step >= 3000);
      issue_i  = ($urandom % 8) != 0;
      b = (($urandom % 4) == 0) ? int'($urandom % NB) : int'($urandom % 3);
      issue_bank_i  = BANK_W'(b);
      issue_row_i   = ROW_W'($urandom % 3);
      issue_burst_i = (($urandom % 2) == 0) ? 8'd32 : 8'd64;
      for (int q = 0; q < QD; q++) begin
        q_valid_i[q] = ($urandom % 3) != 0;
        q_bank_i[q*BANK_W +: BANK_W] = (($urandom % 2) == 0) ? BANK_W'(b) : BANK_W'($urandom % NB);
        q_row_i[q*ROW_W +: ROW_W]    = ROW_W'($urandom % 3);
      end
      for (int k = 0; k < NI; k++) model_step(k);
      @(posedge clk_i);
      @(negedge clk_i);
      for (int k = 0; k < NI; k++) compare(k);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule